// File: doc/BRIEF.md
# Windowed Data Address Translator

This block sits between a core's load/store address and the memory system. It takes a 16-bit data address and decides which physical space the access lands in: internal data RAM, the on-chip I/O area, instruction memory, or one segment of a large unified external memory. The low half of the space and the top quarter are fixed. The quarter from 0x8000 to 0xBFFF is a 16 KB window whose destination a 16-bit map register chooses.

With the map register's instruction select bit set, the window opens onto one of sixteen 16 KB banks of instruction memory. With that bit clear, it opens onto one of eight 16 KB sub-pages inside a 128 KB unified segment, and the map register also names the segment. A 128-bit presence mask says which unified segments exist. An access through the window to an absent segment raises a fault. An access to the I/O quarter outside the small register block at 0xFF00 to 0xFF0F raises a warning.

Translation is combinational from the address and the current map value. One register stage follows it, so every result appears exactly one clock after the request.

Top module: `data_window_xlate`

## Requirements
- R1: After reset, valid_o, io_warn_o and fault_o are low and the map register holds 0, so the first window access lands in unified segment 0, sub-page 0.
- R2: An address from 0x0000 to 0x7FFF gives target 0 (data RAM), offset equal to the address, and seg_o 0.
- R3: An address from 0xC000 to 0xFFFF gives target 1 (I/O), offset equal to the address, and seg_o 0.
- R4: io_warn_o is high for a target-1 access whose address is outside 0xFF00..0xFF0F, and it is low for every other access.
- R5: An address from 0x8000 to 0xBFFF with map bit 12 set gives target 2 (instruction memory) and offset map[3:0]*0x4000 + addr[13:0].
- R6: An address from 0x8000 to 0xBFFF with map bit 12 clear gives target 3 (unified), seg_o = map[9:3], and offset map[2:0]*0x4000 + addr[13:0].
- R7: fault_o is high for a target-3 access when bit seg_o of seg_present_i is 0, and it is low in every other case.
- R8: Results appear on the outputs one cycle after valid_i is high, with valid_o high. In a cycle after valid_i was low, valid_o, io_warn_o and fault_o are low.
- R9: A map write takes effect for requests in later cycles. A request in the same cycle as the write uses the old map. Map bits 15:13 and 11:10 have no effect on any translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe for addr_i |
| addr_i | input | 16 | Core data address |
| map_we_i | input | 1 | Write enable for the map register |
| map_wdata_i | input | 16 | New map register value |
| seg_present_i | input | 128 | Bit n high when unified segment n exists |
| valid_o | output | 1 | Registered result is valid |
| target_o | output | 2 | 0 data RAM, 1 I/O, 2 instruction memory, 3 unified |
| seg_o | output | 7 | Unified segment number, 0 for other targets |
| offset_o | output | 18 | Physical byte offset in the target (within the segment for target 3) |
| io_warn_o | output | 1 | I/O access outside the register block |
| fault_o | output | 1 | Window access to an absent unified segment |

## Verification
The assertions assume that seg_present_i is a settled level in every cycle where valid_i is high. They also assume that map writes arrive as single-cycle strobes with stable data, so a flagged fault can only come from the mask and map value seen in that request's cycle. The stimulus drives every input at the falling edge and holds it through the next rising edge. The mask changes only between requests, and map writes are mixed freely with requests, including writes in the same cycle as a window request. Random addresses are weighted toward the window and the I/O quarter, and directed cases cover the edges of each region and of the I/O register block.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_IO   = 2'd1,
    TGT_IMEM = 2'd2,
    TGT_UMEM = 2'd3
  } tgt_e;
endpackage

// File: rtl/dwx_map_reg.sv
module dwx_map_reg #(
  parameter int MAP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [MAP_W-1:0] wdata_i,
  output logic [MAP_W-1:0] map_o
);
  logic [MAP_W-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   map_q <= '0;
    else if (we_i) map_q <= wdata_i;
  end

  assign map_o = map_q;

  assert_map_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(map_q));
  assert_map_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> map_q == $past(wdata_i));
endmodule

// File: rtl/dwx_decode.sv
module dwx_decode
  import dwx_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int MAP_W        = 16,
  parameter int IBANK_W      = 4,
  parameter int SUB_W        = 3,
  parameter int SEG_W        = 7,
  parameter int IMEM_SEL_BIT = 12,
  parameter logic [ADDR_W-1:0] IO_OK_LO = 16'hFF00,
  parameter logic [ADDR_W-1:0] IO_OK_HI = 16'hFF0F,
  localparam int WIN_BITS = ADDR_W - 2,
  localparam int SEG_CNT  = 1 << SEG_W,
  localparam int OFF_W    = WIN_BITS + IBANK_W
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [MAP_W-1:0]   map_i,
  input  logic [SEG_CNT-1:0] seg_present_i,
  output tgt_e               tgt_o,
  output logic [OFF_W-1:0]   off_o,
  output logic [SEG_W-1:0]   seg_o,
  output logic               warn_o,
  output logic               fault_o
);
  logic [SEG_W-1:0] map_seg;
  assign map_seg = map_i[SUB_W +: SEG_W];

  always_comb begin
    tgt_o   = TGT_DRAM;
    off_o   = OFF_W'(addr_i);
    seg_o   = '0;
    warn_o  = 1'b0;
    fault_o = 1'b0;
    case (addr_i[ADDR_W-1 -: 2])
      2'b11: begin
        tgt_o  = TGT_IO;
        warn_o = (addr_i < IO_OK_LO) || (addr_i > IO_OK_HI);
      end
      2'b10: begin
        if (map_i[IMEM_SEL_BIT]) begin
          tgt_o = TGT_IMEM;
          off_o = OFF_W'({map_i[IBANK_W-1:0], addr_i[WIN_BITS-1:0]});
        end else begin
          tgt_o   = TGT_UMEM;
          seg_o   = map_seg;
          off_o   = OFF_W'({map_i[SUB_W-1:0], addr_i[WIN_BITS-1:0]});
          fault_o = !seg_present_i[map_seg];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dwx_out_reg.sv
module dwx_out_reg
  import dwx_pkg::*;
#(
  parameter int OFF_W = 18,
  parameter int SEG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  tgt_e             tgt_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic             warn_i,
  input  logic             fault_i,
  output logic             valid_o,
  output logic [1:0]       tgt_o,
  output logic [OFF_W-1:0] off_o,
  output logic [SEG_W-1:0] seg_o,
  output logic             warn_o,
  output logic             fault_o
);
  tgt_e             tgt_q;
  logic [OFF_W-1:0] off_q;
  logic [SEG_W-1:0] seg_q;
  logic             valid_q, warn_q, fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      warn_q  <= 1'b0;
      fault_q <= 1'b0;
      tgt_q   <= TGT_DRAM;
      off_q   <= '0;
      seg_q   <= '0;
    end else begin
      valid_q <= valid_i;
      warn_q  <= valid_i & warn_i;
      fault_q <= valid_i & fault_i;
      if (valid_i) begin
        tgt_q <= tgt_i;
        off_q <= off_i;
        seg_q <= seg_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign tgt_o   = tgt_q;
  assign off_o   = off_q;
  assign seg_o   = seg_q;
  assign warn_o  = warn_q;
  assign fault_o = fault_q;

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !warn_o && !fault_o);
  assert_fault_unified_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> valid_o && tgt_o == 2'd3);
  assert_warn_io_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> valid_o && tgt_o == 2'd1);
endmodule

// File: rtl/data_window_xlate.sv
module data_window_xlate
  import dwx_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int MAP_W        = 16,
  parameter int IBANK_W      = 4,
  parameter int SUB_W        = 3,
  parameter int SEG_W        = 7,
  parameter int IMEM_SEL_BIT = 12,
  localparam int WIN_BITS = ADDR_W - 2,
  localparam int SEG_CNT  = 1 << SEG_W,
  localparam int OFF_W    = WIN_BITS + IBANK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               map_we_i,
  input  logic [MAP_W-1:0]   map_wdata_i,
  input  logic [SEG_CNT-1:0] seg_present_i,
  output logic               valid_o,
  output logic [1:0]         target_o,
  output logic [SEG_W-1:0]   seg_o,
  output logic [OFF_W-1:0]   offset_o,
  output logic               io_warn_o,
  output logic               fault_o
);
  logic [MAP_W-1:0] map_q;
  tgt_e             d_tgt;
  logic [OFF_W-1:0] d_off;
  logic [SEG_W-1:0] d_seg;
  logic             d_warn, d_fault;

  dwx_map_reg #(.MAP_W(MAP_W)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (map_we_i),
    .wdata_i(map_wdata_i),
    .map_o  (map_q)
  );

  dwx_decode #(
    .ADDR_W      (ADDR_W),
    .MAP_W       (MAP_W),
    .IBANK_W     (IBANK_W),
    .SUB_W       (SUB_W),
    .SEG_W       (SEG_W),
    .IMEM_SEL_BIT(IMEM_SEL_BIT)
  ) u_dec (
    .addr_i       (addr_i),
    .map_i        (map_q),
    .seg_present_i(seg_present_i),
    .tgt_o        (d_tgt),
    .off_o        (d_off),
    .seg_o        (d_seg),
    .warn_o       (d_warn),
    .fault_o      (d_fault)
  );

  dwx_out_reg #(.OFF_W(OFF_W), .SEG_W(SEG_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .tgt_i  (d_tgt),
    .off_i  (d_off),
    .seg_i  (d_seg),
    .warn_i (d_warn),
    .fault_i(d_fault),
    .valid_o(valid_o),
    .tgt_o  (target_o),
    .off_o  (offset_o),
    .seg_o  (seg_o),
    .warn_o (io_warn_o),
    .fault_o(fault_o)
  );

  assert_low_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !addr_i[ADDR_W-1] |=>
      target_o == 2'd0 && offset_o == OFF_W'($past(addr_i)) && seg_o == '0 && !fault_o);
  assert_top_quarter_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && addr_i[ADDR_W-1 -: 2] == 2'b11 |=>
      target_o == 2'd1 && offset_o == OFF_W'($past(addr_i)));
endmodule

// File: tb/data_window_xlate_bench.sv
module data_window_xlate_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [15:0]  addr_i = '0;
  logic         map_we_i = 1'b0;
  logic [15:0]  map_wdata_i = '0;
  logic [127:0] seg_present_i = '0;
  logic         valid_o;
  logic [1:0]   target_o;
  logic [6:0]   seg_o;
  logic [17:0]  offset_o;
  logic         io_warn_o;
  logic         fault_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] m_map = '0;

  always #10 clk = ~clk;

  data_window_xlate u_data_window_xlate (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .addr_i(addr_i),
    .map_we_i(map_we_i), .map_wdata_i(map_wdata_i), .seg_present_i(seg_present_i),
    .valid_o(valid_o), .target_o(target_o), .seg_o(seg_o), .offset_o(offset_o),
    .io_warn_o(io_warn_o), .fault_o(fault_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  function automatic string region_req(input logic [15:0] a, input logic [15:0] m);
    if (!a[15])      return "R2";
    if (a[15:14] == 2'b11) return "R3";
    if (m[12])       return "R5";
    return "R6";
  endfunction

  // one request cycle, driven at a falling edge and checked at the next one
  task automatic req(input bit v, input logic [15:0] a, input bit we,
                     input logic [15:0] wd, input string tag = "");
    logic [1:0]  e_t;
    logic [17:0] e_o;
    logic [6:0]  e_s;
    bit          e_w, e_f;
    string       r;
    e_t = 2'd0; e_o = 18'(a); e_s = '0; e_w = 0; e_f = 0;
    if (a[15:14] == 2'b11) begin
      e_t = 2'd1;
      e_w = (a < 16'hFF00) || (a > 16'hFF0F);
    end else if (a[15:14] == 2'b10) begin
      if (m_map[12]) begin
        e_t = 2'd2;
        e_o = 18'(m_map[3:0]) * 18'h4000 + 18'(a[13:0]);
      end else begin
        e_t = 2'd3;
        e_s = m_map[9:3];
        e_o = 18'(m_map[2:0]) * 18'h4000 + 18'(a[13:0]);
        e_f = !seg_present_i[m_map[9:3]];
      end
    end
    r = (tag != "") ? tag : region_req(a, m_map);
    valid_i = v; addr_i = a; map_we_i = we; map_wdata_i = wd;
    if (we) m_map = wd;
    @(negedge clk);
    valid_i = 0; map_we_i = 0;
    if (!v) begin
      chk("R8", "valid_o idle", 32'(valid_o), 0);
      chk("R8", "warn idle", 32'(io_warn_o), 0);
      chk("R8", "fault idle", 32'(fault_o), 0);
    end else begin
      chk("R8", "valid_o", 32'(valid_o), 1);
      chk(r, "target", 32'(target_o), 32'(e_t));
      chk(r, "offset", 32'(offset_o), 32'(e_o));
      chk(r, "seg", 32'(seg_o), 32'(e_s));
      chk("R4", "io_warn", 32'(io_warn_o), 32'(e_w));
      chk("R7", "fault", 32'(fault_o), 32'(e_f));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "valid_o in reset", 32'(valid_o), 0);
    chk("R1", "warn in reset", 32'(io_warn_o), 0);
    chk("R1", "fault in reset", 32'(fault_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: map resets to 0 -> unified segment 0, sub-page 0
    seg_present_i = 128'h1;
    req(1, 16'h8123, 0, 0, "R1");
    seg_present_i = '0;
    req(1, 16'h8000, 0, 0, "R7");
    // region edges
    req(1, 16'h0000, 0, 0);
    req(1, 16'h7FFF, 0, 0);
    req(1, 16'hBFFF, 0, 0);
    req(1, 16'hC000, 0, 0);
    // I/O register block edges (R4)
    req(1, 16'hFEFF, 0, 0, "R4");
    req(1, 16'hFF00, 0, 0, "R4");
    req(1, 16'hFF0F, 0, 0, "R4");
    req(1, 16'hFF10, 0, 0, "R4");
    req(1, 16'hFFFF, 0, 0, "R4");
    req(0, 16'hFF10, 0, 0);
    // R9: same-cycle write uses old map, next request sees new map
    seg_present_i = {128{1'b1}};
    req(1, 16'h9000, 1, 16'h1005, "R9");
    req(1, 16'h9000, 0, 0, "R9");
    // R9: bits 15:13 and 11:10 ignored
    req(0, 16'h0, 1, 16'hEC05 | 16'h1000, "R9");
    req(1, 16'h9000, 0, 0, "R9");
    // highest imem bank and highest unified segment/sub-page
    req(0, 16'h0, 1, 16'h100F, "R5");
    req(1, 16'hBFFF, 0, 0, "R5");
    req(0, 16'h0, 1, 16'h03FF, "R6");
    req(1, 16'hBFFF, 0, 0, "R6");
    seg_present_i[127] = 1'b0;
    req(1, 16'h8001, 0, 0, "R7");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      bit v, we;
      if ((i % 50) == 0)
        seg_present_i = {$urandom, $urandom, $urandom, $urandom};
      a = 16'($urandom);
      if (($urandom % 3) == 0) a[15:14] = 2'b10;
      else if (($urandom % 4) == 0) a = 16'hFF00 | 16'($urandom % 32);
      v  = ($urandom % 5) != 0;
      we = ($urandom % 5) == 0;
      req(v, a, we, 16'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule